// File: doc/BRIEF.md
# ADC calibration and conversion control

This block holds the digital control for an analog-to-digital converter. It has two clocks: a register-bus side running on `clk_i` and a converter side running on `conv_clk_i`. Software starts a calibration, then enables the converter and waits for ready, then starts conversions and reads the results. Each delivered result sets an end-of-conversion flag. A result that overwrites data nobody has read sets an overrun flag.

The converter is a stub. It samples `ain_i` when a conversion is accepted and returns that value a fixed number of converter clocks later. Calibration requests, enable, start and result delivery cross between the two domains. Each crossing goes through a two-flop synchronizer and uses a toggle or level handshake. The result word itself is held stable and does not need one.

After a calibration finishes, the converter side keeps a hold window of four converter clocks. During that window the enable bit is forced low, so an enable written too early is lost.

Top module: `adcc_top`

## Requirements
- R1: A calibration request (write 1 to bit 0 of the control register at address 0) is taken only while the enable bit (control bit 1) is 0. If enable is 1, the request is ignored and control bit 0 keeps reading 0.
- R2: Once a calibration request is accepted, control bit 0 reads 1 on the next bus cycle. It stays 1 for the whole calibration and returns to 0 when the converter side reports completion.
- R3: Calibration requests issued back to back, each written as soon as the previous one reads 0, each run to completion and clear. None is lost and none leaves bit 0 stuck at 1.
- R4: For four converter clocks after a calibration completes, the enable bit is held at 0. An enable written during that window, or while bit 0 reads 1, is lost. An enable written after the window is kept.
- R5: Ready (status bit 0 at address 1) rises two converter clocks after the converter side sees enable, then crosses to the bus. It falls after enable is cleared. A start (control bit 2) is taken only while enable and ready both read 1; otherwise it is ignored and no result follows.
- R6: An accepted start makes control bit 2 read 1 until the result arrives. The result then holds the sampled `ain_i` value in the data register (address 2, low bits) and sets end-of-conversion (status bit 1).
- R7: End-of-conversion is cleared by a data register read (`rd_i` with address 2) or by writing 1 to status bit 1.
- R8: A result that arrives while end-of-conversion is set raises overrun (status bit 2), and the data register holds the newest result. This also holds when a clear by read or by write lands in the same bus cycle as the new data. In that case end-of-conversion stays 1.
- R9: Overrun is sticky. Only writing 1 to status bit 2 clears it. Clearing end-of-conversion or reading data leaves it set.
- R10: After reset, the control, status and data registers all read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register-bus clock |
| conv_clk_i | input | 1 | Converter clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe, used for the data-read clear |
| wdata_i | input | BUS_W | Write data |
| rdata_o | output | BUS_W | Read data for `addr_i`, combinational |
| ain_i | input | DATA_W | Stub analog input, sampled at conversion start |

## Verification
The bench aims at the exact bus cycle in which a result lands. It watches control bit 2 drop and fires a status clear, or a data read, into the following cycle. A design that computes overrun from the already-cleared flag would leave overrun at 0 and lose end-of-conversion for data nobody has read.

The bench also writes enable right after calibration clears and writes calibrate while enabled. A design that ignores the hold window would keep the enable. A design that gates calibrate wrongly would start a calibration while enabled.

Calibrations are chained back to back with a bus clock about seven times faster than the converter clock. A handshake that drops a toggle would leave bit 0 stuck at 1.

A sweep over sixteen input values alternates the two ways of clearing. This catches a wrong data width or a clear path that does nothing.

// File: rtl/adcc_pkg.sv
package adcc_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  localparam int B_CAL   = 0;
  localparam int B_EN    = 1;
  localparam int B_START = 2;
  localparam int B_RDY   = 0;
  localparam int B_EOC   = 1;
  localparam int B_OVR   = 2;

  typedef enum logic [1:0] {CAL_IDLE, CAL_RUN, CAL_HOLD} cal_st_e;
endpackage

// File: rtl/adcc_sync.sv
module adcc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/adcc_conv_core.sv
module adcc_conv_core
  import adcc_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int CAL_CYCLES  = 16,
  parameter int KILL_CYCLES = 4,
  parameter int RDY_CYCLES  = 2,
  parameter int CONV_CYCLES = 6
) (
  input  logic              conv_clk_i,
  input  logic              rst_ni,
  input  logic              cal_req_i,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] ain_i,
  output logic              cal_ack_o,
  output logic              hold_o,
  output logic              rdy_o,
  output logic              res_tgl_o,
  output logic [DATA_W-1:0] res_data_o
);
  localparam int CNT_W  = $clog2(CAL_CYCLES + KILL_CYCLES + 1);
  localparam int RCNT_W = $clog2(RDY_CYCLES + 1);
  localparam int CCNT_W = $clog2(CONV_CYCLES + 1);

  // calibration sequencer
  cal_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ack_q, ack_d, hold_q, cal_pend;

  assign cal_pend = cal_req_i ^ ack_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    ack_d = ack_q;
    unique case (st_q)
      CAL_IDLE: if (cal_pend) begin
        st_d  = CAL_RUN;
        cnt_d = CNT_W'(CAL_CYCLES - 1);
      end
      CAL_RUN: if (cnt_q == '0) begin
        st_d  = CAL_HOLD;
        ack_d = ~ack_q;
        cnt_d = CNT_W'(KILL_CYCLES - 1);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      CAL_HOLD: if (cal_pend) begin
        st_d  = CAL_RUN;
        cnt_d = CNT_W'(CAL_CYCLES - 1);
      end else if (cnt_q == '0) begin
        st_d = CAL_IDLE;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      default: st_d = CAL_IDLE;
    endcase
  end

  always_ff @(posedge conv_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= CAL_IDLE;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ack_q  <= ack_d;
      hold_q <= (st_d != CAL_IDLE);
    end
  end

  // ready after RDY_CYCLES clocks of enable
  logic [RCNT_W-1:0] rcnt_q;
  logic              rdy_q;

  always_ff @(posedge conv_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rcnt_q <= '0;
      rdy_q  <= 1'b0;
    end else if (!en_i) begin
      rcnt_q <= '0;
      rdy_q  <= 1'b0;
    end else if (!rdy_q) begin
      rcnt_q <= rcnt_q + 1'b1;
      rdy_q  <= (rcnt_q == RCNT_W'(RDY_CYCLES - 1));
    end
  end

  // converter stub
  logic              busy_q, res_tgl_q, start_pend;
  logic [CCNT_W-1:0] ccnt_q;
  logic [DATA_W-1:0] smp_q, res_q;

  assign start_pend = start_i ^ res_tgl_q;

  always_ff @(posedge conv_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      ccnt_q    <= '0;
      smp_q     <= '0;
      res_q     <= '0;
      res_tgl_q <= 1'b0;
    end else if (!busy_q) begin
      if (start_pend) begin
        busy_q <= 1'b1;
        smp_q  <= ain_i;
        ccnt_q <= CCNT_W'(CONV_CYCLES - 1);
      end
    end else if (ccnt_q == '0) begin
      busy_q    <= 1'b0;
      res_q     <= smp_q;
      res_tgl_q <= ~res_tgl_q;
    end else begin
      ccnt_q <= ccnt_q - 1'b1;
    end
  end

  assign cal_ack_o  = ack_q;
  assign hold_o     = hold_q;
  assign rdy_o      = rdy_q;
  assign res_tgl_o  = res_tgl_q;
  assign res_data_o = res_q;

  // R3
  cal_not_lost_chk: assert property (@(posedge conv_clk_i) disable iff (!rst_ni)
    (st_q != CAL_RUN && cal_pend) |=> st_q == CAL_RUN);
  // R2
  cal_run_pending_chk: assert property (@(posedge conv_clk_i) disable iff (!rst_ni)
    st_q == CAL_RUN |-> cal_pend);
  // R5
  rdy_delay_chk: assert property (@(posedge conv_clk_i) disable iff (!rst_ni)
    $rose(rdy_q) |-> ($past(en_i) && $past(en_i, 2)));
  // R5
  rdy_drop_chk: assert property (@(posedge conv_clk_i) disable iff (!rst_ni)
    !en_i |=> !rdy_q);
endmodule

// File: rtl/adcc_bus_regs.sv
module adcc_bus_regs
  import adcc_pkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              cal_ack_i,
  input  logic              hold_i,
  input  logic              rdy_i,
  input  logic              res_tgl_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic              cal_req_o,
  output logic              en_o,
  output logic              start_o
);
  logic              cal_tgl_q, en_q, start_tgl_q, res_seen_q, eoc_q, ovr_q;
  logic [DATA_W-1:0] data_q;
  logic              cal_bit, start_pend, ctrl_wr, stat_wr, cal_go, start_go;
  logic              new_data, eoc_clr, ovr_clr;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[BUS_W-1:3];

  assign cal_bit    = cal_tgl_q ^ cal_ack_i;
  assign start_pend = start_tgl_q ^ res_tgl_i;
  assign ctrl_wr    = wr_i && addr_i == A_CTRL;
  assign stat_wr    = wr_i && addr_i == A_STAT;
  assign cal_go     = ctrl_wr && wdata_i[B_CAL] && !cal_bit && !en_q;
  assign start_go   = ctrl_wr && wdata_i[B_START] && en_q && rdy_i && !start_pend;
  assign new_data   = res_tgl_i ^ res_seen_q;
  assign eoc_clr    = (rd_i && addr_i == A_DATA) || (stat_wr && wdata_i[B_EOC]);
  assign ovr_clr    = stat_wr && wdata_i[B_OVR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_tgl_q   <= 1'b0;
      en_q        <= 1'b0;
      start_tgl_q <= 1'b0;
      res_seen_q  <= 1'b0;
      eoc_q       <= 1'b0;
      ovr_q       <= 1'b0;
      data_q      <= '0;
    end else begin
      if (cal_go) cal_tgl_q <= ~cal_tgl_q;
      // hold window and running calibration both drop enable
      if (hold_i || cal_bit) en_q <= 1'b0;
      else if (ctrl_wr && !cal_go) en_q <= wdata_i[B_EN];
      if (start_go) start_tgl_q <= ~start_tgl_q;
      res_seen_q <= res_tgl_i;
      // new data wins over a clear in the same cycle
      if (new_data) begin
        data_q <= res_data_i;
        eoc_q  <= 1'b1;
      end else if (eoc_clr) begin
        eoc_q <= 1'b0;
      end
      if (new_data && eoc_q) ovr_q <= 1'b1;
      else if (ovr_clr) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL: begin
        rdata_o[B_CAL]   = cal_bit;
        rdata_o[B_EN]    = en_q;
        rdata_o[B_START] = start_pend;
      end
      A_STAT: begin
        rdata_o[B_RDY] = rdy_i;
        rdata_o[B_EOC] = eoc_q;
        rdata_o[B_OVR] = ovr_q;
      end
      A_DATA:  rdata_o[DATA_W-1:0] = data_q;
      default: rdata_o = '0;
    endcase
  end

  assign cal_req_o = cal_tgl_q;
  assign en_o      = en_q;
  assign start_o   = start_tgl_q;

  // R1
  cal_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> cal_tgl_q == $past(cal_tgl_q));
  // R4
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !en_q);
  // R6
  eoc_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_data |=> eoc_q);
  // R7
  eoc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_clr && !new_data) |=> !eoc_q);
  // R8
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (new_data && eoc_q) |=> ovr_q);
  // R9
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !ovr_clr) |=> ovr_q);
endmodule

// File: rtl/adcc_top.sv
module adcc_top
  import adcc_pkg::*;
#(
  parameter int BUS_W       = 16,
  parameter int DATA_W      = 12,
  parameter int CAL_CYCLES  = 16,
  parameter int KILL_CYCLES = 4,
  parameter int RDY_CYCLES  = 2,
  parameter int CONV_CYCLES = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              conv_clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic [DATA_W-1:0] ain_i
);
  logic              cal_req, en, start_tgl;
  logic              cal_req_s, en_s, start_s;
  logic              cal_ack, hold, rdy, res_tgl;
  logic              cal_ack_s, hold_s, rdy_s, res_tgl_s;
  logic [DATA_W-1:0] res_data;

  adcc_bus_regs #(.BUS_W(BUS_W), .DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_i       (wr_i),
    .rd_i       (rd_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .cal_ack_i  (cal_ack_s),
    .hold_i     (hold_s),
    .rdy_i      (rdy_s),
    .res_tgl_i  (res_tgl_s),
    .res_data_i (res_data),
    .cal_req_o  (cal_req),
    .en_o       (en),
    .start_o    (start_tgl)
  );

  adcc_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync_b2c (
    .clk_i  (conv_clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cal_req, en, start_tgl}),
    .q_o    ({cal_req_s, en_s, start_s})
  );

  adcc_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync_c2b (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({cal_ack, hold, rdy, res_tgl}),
    .q_o    ({cal_ack_s, hold_s, rdy_s, res_tgl_s})
  );

  adcc_conv_core #(
    .DATA_W      (DATA_W),
    .CAL_CYCLES  (CAL_CYCLES),
    .KILL_CYCLES (KILL_CYCLES),
    .RDY_CYCLES  (RDY_CYCLES),
    .CONV_CYCLES (CONV_CYCLES)
  ) u_core (
    .conv_clk_i (conv_clk_i),
    .rst_ni     (rst_ni),
    .cal_req_i  (cal_req_s),
    .en_i       (en_s),
    .start_i    (start_s),
    .ain_i      (ain_i),
    .cal_ack_o  (cal_ack),
    .hold_o     (hold),
    .rdy_o      (rdy),
    .res_tgl_o  (res_tgl),
    .res_data_o (res_data)
  );
endmodule

// File: tb/adcc_top_bench.sv
module adcc_top_bench;
  import adcc_pkg::*;
  localparam int BUS_W  = 16;
  localparam int DATA_W = 12;
  localparam int LIM    = 3000;

  logic              clk = 1'b0, conv_clk = 1'b0, rst_n = 1'b0;
  logic [1:0]        addr = 2'd0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [BUS_W-1:0]  wdata = '0, rdata;
  logic [DATA_W-1:0] ain = '0;
  int                n_chk = 0, n_err = 0;

  always #2 clk = ~clk;
  always #15 conv_clk = ~conv_clk;

  adcc_top u_adcc_top (
    .clk_i(clk), .conv_clk_i(conv_clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr),
    .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .ain_i(ain)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, input logic strobe, output logic [BUS_W-1:0] v);
    @(negedge clk); addr = a; rd = strobe; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic poll(input logic [1:0] a, input int b, input logic val, output logic ok);
    ok = 1'b0;
    for (int n = 0; n < LIM; n++) begin
      @(negedge clk); addr = a; #1;
      if (rdata[b] === val) begin ok = 1'b1; break; end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic convert(input logic [DATA_W-1:0] v, output logic ok);
    ain = v;
    wr_reg(A_CTRL, BUS_W'((1 << B_EN) | (1 << B_START)));
    poll(A_CTRL, B_START, 1'b0, ok);
  endtask

  // collision: fire a clear into the cycle the result is captured
  task automatic collide(input logic [DATA_W-1:0] v, input logic use_read, output logic hit);
    hit = 1'b0;
    ain = v;
    wr_reg(A_CTRL, BUS_W'((1 << B_EN) | (1 << B_START)));
    for (int n = 0; n < LIM; n++) begin
      @(negedge clk); addr = A_CTRL; #1;
      if (rdata[B_START] == 1'b0) begin
        if (use_read) begin addr = A_DATA; rd = 1'b1; end
        else begin addr = A_STAT; wdata = BUS_W'(1 << B_EOC); wr = 1'b1; end
        @(negedge clk); rd = 1'b0; wr = 1'b0;
        hit = 1'b1;
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [BUS_W-1:0] v;
    logic             ok;
    logic [DATA_W-1:0] a_val, b_val;

    #50 rst_n = 1'b1;
    idle(4);

    // R10 reset state
    rd_reg(A_CTRL, 1'b0, v); chk("R10 ctrl", v, 0);
    rd_reg(A_STAT, 1'b0, v); chk("R10 status", v, 0);
    rd_reg(A_DATA, 1'b0, v); chk("R10 data", v, 0);

    // R5 start ignored while disabled
    wr_reg(A_CTRL, BUS_W'(1 << B_START));
    rd_reg(A_CTRL, 1'b0, v); chk("R5 start ignored", v, 0);
    idle(200);
    rd_reg(A_STAT, 1'b0, v); chk("R5 no result", v, 0);

    // R5 ready after enable
    wr_reg(A_CTRL, BUS_W'(1 << B_EN));
    poll(A_STAT, B_RDY, 1'b1, ok); chk("R5 ready rises", ok, 1);

    // R1 calibrate ignored while enabled
    wr_reg(A_CTRL, BUS_W'((1 << B_CAL) | (1 << B_EN)));
    rd_reg(A_CTRL, 1'b0, v); chk("R1 cal ignored", v, BUS_W'(1 << B_EN));
    idle(100);
    rd_reg(A_CTRL, 1'b0, v); chk("R1 cal still idle", v, BUS_W'(1 << B_EN));

    // R5 ready falls
    wr_reg(A_CTRL, '0);
    poll(A_STAT, B_RDY, 1'b0, ok); chk("R5 ready falls", ok, 1);

    // R2 calibrate bit lifetime
    wr_reg(A_CTRL, BUS_W'(1 << B_CAL));
    rd_reg(A_CTRL, 1'b0, v); chk("R2 cal reads 1", v[B_CAL], 1);
    idle(40);
    rd_reg(A_CTRL, 1'b0, v); chk("R2 cal held", v[B_CAL], 1);
    poll(A_CTRL, B_CAL, 1'b0, ok); chk("R2 cal clears", ok, 1);

    // R3 back-to-back calibrations, each issued as soon as the last clears
    for (int k = 0; k < 3; k++) begin
      wr_reg(A_CTRL, BUS_W'(1 << B_CAL));
      rd_reg(A_CTRL, 1'b0, v); chk("R3 cal accepted", v[B_CAL], 1);
      poll(A_CTRL, B_CAL, 1'b0, ok); chk("R3 cal completes", ok, 1);
    end

    // R4 enable inside hold window is lost
    wr_reg(A_CTRL, BUS_W'(1 << B_EN));
    idle(60);
    rd_reg(A_CTRL, 1'b0, v); chk("R4 early enable lost", v[B_EN], 0);
    wr_reg(A_CTRL, BUS_W'(1 << B_EN));
    idle(60);
    rd_reg(A_CTRL, 1'b0, v); chk("R4 late enable kept", v[B_EN], 1);
    poll(A_STAT, B_RDY, 1'b1, ok); chk("R5 ready after cal", ok, 1);

    // R6 R7 sweep, alternating read clear and write-one clear
    for (int i = 0; i < 16; i++) begin
      logic [DATA_W-1:0] x;
      x = DATA_W'(i * 273 + 5);
      convert(x, ok); chk("R6 start done", ok, 1);
      rd_reg(A_STAT, 1'b0, v); chk("R6 eoc set", v, BUS_W'((1 << B_RDY) | (1 << B_EOC)));
      if (i % 2 == 0) begin
        rd_reg(A_DATA, 1'b1, v); chk("R6 data", v, BUS_W'(x));
      end else begin
        rd_reg(A_DATA, 1'b0, v); chk("R6 data", v, BUS_W'(x));
        wr_reg(A_STAT, BUS_W'(1 << B_EOC));
      end
      rd_reg(A_STAT, 1'b0, v); chk("R7 eoc cleared", v, BUS_W'(1 << B_RDY));
    end

    // R8 plain overrun, R9 sticky
    a_val = 12'h3a5; b_val = 12'hc5a;
    convert(a_val, ok);
    convert(b_val, ok);
    rd_reg(A_STAT, 1'b0, v); chk("R8 overrun", v, BUS_W'(7));
    rd_reg(A_DATA, 1'b1, v); chk("R8 newest data", v, BUS_W'(b_val));
    wr_reg(A_STAT, BUS_W'(1 << B_EOC));
    rd_reg(A_STAT, 1'b0, v); chk("R9 ovr survives eoc clear", v, BUS_W'((1 << B_RDY) | (1 << B_OVR)));
    wr_reg(A_STAT, BUS_W'(1 << B_OVR));
    rd_reg(A_STAT, 1'b0, v); chk("R9 ovr w1c", v, BUS_W'(1 << B_RDY));

    // R8 collision with write-one clear
    convert(12'h111, ok);
    collide(12'h222, 1'b0, ok); chk("R8 collide hit", ok, 1);
    rd_reg(A_STAT, 1'b0, v); chk("R8 collide write flags", v, BUS_W'(7));
    rd_reg(A_DATA, 1'b1, v); chk("R8 collide write data", v, BUS_W'(12'h222));
    wr_reg(A_STAT, BUS_W'((1 << B_EOC) | (1 << B_OVR)));

    // R8 collision with data read
    convert(12'h333, ok);
    collide(12'h444, 1'b1, ok); chk("R8 collide read hit", ok, 1);
    rd_reg(A_STAT, 1'b0, v); chk("R8 collide read flags", v, BUS_W'(7));
    rd_reg(A_DATA, 1'b1, v); chk("R8 collide read data", v, BUS_W'(12'h444));
    rd_reg(A_STAT, 1'b0, v); chk("R9 ovr after read", v, BUS_W'((1 << B_RDY) | (1 << B_OVR)));

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule